// File: doc/BRIEF.md
# Mask-Driven Pixel Channel Extractor

This block takes packed pixel words and splits each one into red, green and blue values. Software writes three channel masks, a bits-per-pixel value and a byte-order flag. On every such write the block scans the three masks one bit per cycle and works out, for each channel, how far its field sits from bit zero (the shift) and how many bits it spans (the width). It also ranks the three channels by shift, so the channel sitting in the lowest bits of the word gets rank 0.

Once the scan is over, pixels stream in on a valid/ready input. Each pixel word may first have its bytes reversed, when the byte-order flag says the most significant byte comes first, and then has every bit above the pixel depth cleared. Each channel is then masked and shifted down to bit zero and delivered as an 8-bit value on a valid/ready output. Back-pressure rules: a pixel is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when no scan is running, the configured depth is a supported one, and the output register is empty or being drained in the same cycle. The output holds its values unchanged for as long as `out_valid` is high and `out_ready` is low.

Top module: `pixel_chan_extract`

## Requirements
- R1: After a scan, each channel's reported shift equals the count of zero bits below the lowest set bit of its mask.
- R2: After a scan, each channel's reported width equals the count of set bits in its mask.
- R3: Each output channel equals (prepared word AND mask) shifted right by the channel's shift, keeping the lowest 8 bits, with narrower fields zero-extended on the left.
- R4: A mask of all zeros reports shift 0 and width 0, and that channel's output is always 0.
- R5: With `cfg_msb_first` = 1, the lowest N bytes of the pixel are reversed before masking, where N is 1 for depths up to 8, 2 for 15 and 16, 3 for 24 and 4 for 32; with the flag at 0 the byte order is left alone.
- R6: Pixel bits at or above the configured depth have no effect on any output; at depth 15 bit 15 is unused.
- R7: Only depths 1, 2, 4, 8, 15, 16, 24 and 32 are supported; with any other depth `in_ready` stays low.
- R8: Ranks (0, 1, 2) give each channel the number of other channels with a smaller shift, ties broken red before green before blue; the three ranks are always distinct.
- R9: After a configuration write, `in_ready` is low for exactly 32 (the pixel width) cycles and then returns high for a supported depth.
- R10: While `out_valid` is high and `out_ready` low, the output values stay stable and no new pixel is taken; a new pixel may be taken in the same cycle that the old output drains.
- R11: After reset the masks are zero, depth is 32, `in_ready` is high, `out_valid` low and all shifts and widths read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe; starts a mask scan |
| cfg_mask_red | input | 32 | Red channel mask |
| cfg_mask_grn | input | 32 | Green channel mask |
| cfg_mask_blu | input | 32 | Blue channel mask |
| cfg_bpp | input | 6 | Bits per pixel |
| cfg_msb_first | input | 1 | 1 = most significant byte first (bytes reversed) |
| in_valid | input | 1 | Pixel input valid |
| in_ready | output | 1 | Pixel input ready |
| in_pix | input | 32 | Packed pixel word |
| out_valid | output | 1 | Channel output valid |
| out_ready | input | 1 | Channel output ready |
| out_red | output | 8 | Red channel value |
| out_grn | output | 8 | Green channel value |
| out_blu | output | 8 | Blue channel value |
| shift_red | output | 6 | Red shift |
| shift_grn | output | 6 | Green shift |
| shift_blu | output | 6 | Blue shift |
| width_red | output | 6 | Red width |
| width_grn | output | 6 | Green width |
| width_blu | output | 6 | Blue width |
| rank_red | output | 2 | Red position rank |
| rank_grn | output | 2 | Green position rank |
| rank_blu | output | 2 | Blue position rank |

## Verification
The bench builds the block with its defaults, a 32-bit pixel word and 8-bit channels. That word size makes every supported container size reachable, from one byte up to four, so the byte reversal is exercised over two, three and four bytes, and it lets a mask span ten bits so that truncation of a field wider than the channel shows up at the outputs. The 32-cycle scan length is measured directly against the pixel width.

// File: rtl/pce_pkg.sv
package pce_pkg;

  localparam int unsigned NUM_CH = 3;

  // Depth values the block accepts, bounded by the pixel word width.
  function automatic logic depth_ok(input int bpp, input int pix_w);
    logic hit;
    hit = (bpp == 1) || (bpp == 2) || (bpp == 4) || (bpp == 8) ||
          (bpp == 15) || (bpp == 16) || (bpp == 24) || (bpp == 32);
    return hit && (bpp <= pix_w);
  endfunction

  // Bytes a pixel occupies for a given depth.
  function automatic int container_bytes(input int bpp);
    if (bpp <= 8)       return 1;
    else if (bpp <= 16) return 2;
    else if (bpp <= 24) return 3;
    else                return 4;
  endfunction

endpackage

// File: rtl/pce_mask_scan.sv
module pce_mask_scan #(
  parameter int unsigned PIX_W = 32,
  parameter int unsigned SH_W  = $clog2(PIX_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            step,
  input  logic            mask_bit,
  output logic [SH_W-1:0] shift_o,
  output logic [SH_W-1:0] width_o
);

  logic [SH_W-1:0] zeros_q;
  logic [SH_W-1:0] ones_q;
  logic            seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zeros_q <= '0;
      ones_q  <= '0;
      seen_q  <= 1'b0;
    end else if (start) begin
      zeros_q <= '0;
      ones_q  <= '0;
      seen_q  <= 1'b0;
    end else if (step) begin
      if (mask_bit) begin
        ones_q <= ones_q + 1'b1;
        seen_q <= 1'b1;
      end else if (!seen_q) begin
        zeros_q <= zeros_q + 1'b1;
      end
    end
  end

  // An empty mask leaves the zero counter at full scale; report 0 instead.
  assign shift_o = (ones_q == '0) ? '0 : zeros_q;
  assign width_o = ones_q;

  assert_field_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start) |-> ({1'b0, shift_o} + {1'b0, width_o}) <= (SH_W + 1)'(PIX_W));

  assert_width_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start) |=> (width_o >= $past(width_o)));

endmodule

// File: rtl/pce_word_prep.sv
module pce_word_prep
  import pce_pkg::*;
#(
  parameter int unsigned PIX_W = 32,
  parameter int unsigned BPP_W = $clog2(PIX_W + 1)
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic [BPP_W-1:0] bpp_i,
  input  logic             msb_first_i,
  output logic [PIX_W-1:0] word_o
);

  localparam int unsigned NB = PIX_W / 8;

  int              nbytes;
  logic [PIX_W-1:0] swapped;
  logic [PIX_W-1:0] keep;

  assign nbytes = container_bytes(int'(bpp_i));

  always_comb begin
    swapped = '0;
    for (int i = 0; i < NB; i++) begin
      if (!msb_first_i) begin
        swapped[i*8 +: 8] = pix_i[i*8 +: 8];
      end else begin
        for (int j = 0; j < NB; j++) begin
          if ((i < nbytes) && (j == nbytes - 1 - i))
            swapped[i*8 +: 8] = pix_i[j*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < PIX_W; k++)
      keep[k] = (k < int'(bpp_i));
  end

  assign word_o = swapped & keep;

endmodule

// File: rtl/pce_chan_order.sv
module pce_chan_order #(
  parameter int unsigned SH_W = 6
) (
  input  logic [2:0][SH_W-1:0] shift_i,
  output logic [2:0][1:0]      rank_o
);

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      rank_o[c] = 2'd0;
      for (int o = 0; o < 3; o++) begin
        if (o != c) begin
          if ((shift_i[o] < shift_i[c]) || ((shift_i[o] == shift_i[c]) && (o < c)))
            rank_o[c] = rank_o[c] + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/pixel_chan_extract.sv
module pixel_chan_extract
  import pce_pkg::*;
#(
  parameter int unsigned PIX_W = 32,
  parameter int unsigned CH_W  = 8,
  parameter int unsigned SH_W  = $clog2(PIX_W + 1),
  parameter int unsigned BPP_W = $clog2(PIX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PIX_W-1:0] cfg_mask_red,
  input  logic [PIX_W-1:0] cfg_mask_grn,
  input  logic [PIX_W-1:0] cfg_mask_blu,
  input  logic [BPP_W-1:0] cfg_bpp,
  input  logic             cfg_msb_first,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CH_W-1:0]  out_red,
  output logic [CH_W-1:0]  out_grn,
  output logic [CH_W-1:0]  out_blu,
  output logic [SH_W-1:0]  shift_red,
  output logic [SH_W-1:0]  shift_grn,
  output logic [SH_W-1:0]  shift_blu,
  output logic [SH_W-1:0]  width_red,
  output logic [SH_W-1:0]  width_grn,
  output logic [SH_W-1:0]  width_blu,
  output logic [1:0]       rank_red,
  output logic [1:0]       rank_grn,
  output logic [1:0]       rank_blu
);

  localparam int unsigned IDX_W = $clog2(PIX_W);

  // Configuration state
  logic [2:0][PIX_W-1:0] msk_q;
  logic [BPP_W-1:0]      bpp_q;
  logic                  msb_q;
  logic                  busy_q;
  logic [IDX_W-1:0]      idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q  <= '0;
      bpp_q  <= BPP_W'(PIX_W);
      msb_q  <= 1'b0;
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (cfg_we) begin
      msk_q  <= {cfg_mask_blu, cfg_mask_grn, cfg_mask_red};
      bpp_q  <= cfg_bpp;
      msb_q  <= cfg_msb_first;
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == IDX_W'(PIX_W - 1)) busy_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  // Per-channel mask scanners
  logic [2:0][SH_W-1:0] shift_a;
  logic [2:0][SH_W-1:0] width_a;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_scan
    pce_mask_scan #(
      .PIX_W (PIX_W),
      .SH_W  (SH_W)
    ) i_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cfg_we),
      .step     (busy_q),
      .mask_bit (msk_q[c][idx_q]),
      .shift_o  (shift_a[c]),
      .width_o  (width_a[c])
    );
  end

  // Pixel word preparation
  logic [PIX_W-1:0] word;

  pce_word_prep #(
    .PIX_W (PIX_W),
    .BPP_W (BPP_W)
  ) i_prep (
    .pix_i       (in_pix),
    .bpp_i       (bpp_q),
    .msb_first_i (msb_q),
    .word_o      (word)
  );

  // Channel order
  logic [2:0][1:0] rank_a;

  pce_chan_order #(
    .SH_W (SH_W)
  ) i_order (
    .shift_i (shift_a),
    .rank_o  (rank_a)
  );

  // Field extraction
  logic [2:0][CH_W-1:0] val_a;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_field
    logic [PIX_W-1:0] fld;
    always_comb begin
      fld      = (word & msk_q[c]) >> shift_a[c];
      val_a[c] = (width_a[c] == '0) ? '0 : fld[CH_W-1:0];
    end
  end

  // Stream control
  logic depth_good;
  logic in_fire;

  assign depth_good = depth_ok(int'(bpp_q), PIX_W);
  assign in_ready   = !busy_q && depth_good && (!out_valid || out_ready);
  assign in_fire    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_red   <= '0;
      out_grn   <= '0;
      out_blu   <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_red   <= val_a[0];
      out_grn   <= val_a[1];
      out_blu   <= val_a[2];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign shift_red = shift_a[0];
  assign shift_grn = shift_a[1];
  assign shift_blu = shift_a[2];
  assign width_red = width_a[0];
  assign width_grn = width_a[1];
  assign width_blu = width_a[2];
  assign rank_red  = rank_a[0];
  assign rank_grn  = rank_a[1];
  assign rank_blu  = rank_a[2];

  // Checks on the block's own behaviour
  assert_cfg_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !in_ready);

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_red) && $stable(out_grn) && $stable(out_blu)));

  assert_rank_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_red != rank_grn) && (rank_red != rank_blu) && (rank_grn != rank_blu));

  assert_empty_mask_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && (width_red == '0)) |=> (out_red == '0));

  assert_depth15_top_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bpp_q == BPP_W'(15)) |-> (word[PIX_W-1:15] == '0));

endmodule

// File: tb/test_pixel_chan_extract.sv
module test_pixel_chan_extract;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_mask_red = '0, cfg_mask_grn = '0, cfg_mask_blu = '0;
  logic [5:0]  cfg_bpp = 6'd32;
  logic        cfg_msb_first = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pix = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_red, out_grn, out_blu;
  logic [5:0]  shift_red, shift_grn, shift_blu;
  logic [5:0]  width_red, width_grn, width_blu;
  logic [1:0]  rank_red, rank_grn, rank_blu;

  int n_cmp = 0;
  int n_bad = 0;

  // Bench copy of the current configuration, for expected values
  logic [31:0] m_r, m_g, m_b;
  int          m_bpp;
  logic        m_msb;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_chan_extract i_pixel_chan_extract (
    .clk, .rst_n, .cfg_we, .cfg_mask_red, .cfg_mask_grn, .cfg_mask_blu,
    .cfg_bpp, .cfg_msb_first, .in_valid, .in_ready, .in_pix, .out_valid,
    .out_ready, .out_red, .out_grn, .out_blu, .shift_red, .shift_grn,
    .shift_blu, .width_red, .width_grn, .width_blu, .rank_red, .rank_grn,
    .rank_blu
  );

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int tz(input logic [31:0] m);
    if (m == 0) return 0;
    for (int i = 0; i < 32; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int pop(input logic [31:0] m);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic logic [31:0] prep(input logic [31:0] p);
    logic [31:0] w;
    int nb;
    nb = (m_bpp <= 8) ? 1 : (m_bpp <= 16) ? 2 : (m_bpp <= 24) ? 3 : 4;
    if (m_msb) begin
      w = '0;
      for (int i = 0; i < nb; i++) w[i*8 +: 8] = p[(nb-1-i)*8 +: 8];
    end else w = p;
    if (m_bpp < 32) w = w & ((32'd1 << m_bpp) - 32'd1);
    return w;
  endfunction

  function automatic logic [7:0] field(input logic [31:0] w, input logic [31:0] m);
    logic [31:0] t;
    t = (w & m) >> tz(m);
    return t[7:0];
  endfunction

  task automatic configure(input logic [31:0] r, g, b, input int bpp,
                           input logic msb, input bit wait_ready);
    @(negedge clk);
    cfg_mask_red = r; cfg_mask_grn = g; cfg_mask_blu = b;
    cfg_bpp = 6'(bpp); cfg_msb_first = msb; cfg_we = 1'b1;
    m_r = r; m_g = g; m_b = b; m_bpp = bpp; m_msb = msb;
    @(negedge clk);
    cfg_we = 1'b0;
    if (wait_ready)
      for (int k = 0; k < 100 && !in_ready; k++) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] p, input string req);
    logic [31:0] w;
    w = prep(p);
    @(negedge clk);
    in_valid = 1'b1; in_pix = p;
    for (int k = 0; k < 100 && !in_ready; k++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, 32'(out_valid), 32'd1);
    chk({req, " red"}, 32'(out_red), 32'(field(w, m_r)));
    chk({req, " grn"}, 32'(out_grn), 32'(field(w, m_g)));
    chk({req, " blu"}, 32'(out_blu), 32'(field(w, m_b)));
  endtask

  task automatic t_reset();
    chk("R11 in_ready", 32'(in_ready), 32'd1);
    chk("R11 out_valid", 32'(out_valid), 32'd0);
    chk("R11 shift_red", 32'(shift_red), 32'd0);
    chk("R11 width_blu", 32'(width_blu), 32'd0);
  endtask

  task automatic t_rgb24();
    configure(32'h00FF0000, 32'h0000FF00, 32'h000000FF, 24, 1'b0, 1);
    chk("R1 shift_red", 32'(shift_red), 32'(tz(m_r)));
    chk("R1 shift_grn", 32'(shift_grn), 32'(tz(m_g)));
    chk("R1 shift_blu", 32'(shift_blu), 32'd0);
    chk("R2 width_red", 32'(width_red), 32'(pop(m_r)));
    chk("R8 rank_red", 32'(rank_red), 32'd2);
    chk("R8 rank_grn", 32'(rank_grn), 32'd1);
    chk("R8 rank_blu", 32'(rank_blu), 32'd0);
    send(32'h00123456, "R3 rgb24");
    send(32'hFFA5C30F, "R6 rgb24 top byte");
    chk("R6 red literal", 32'(out_red), 32'hA5);
  endtask

  task automatic t_swap();
    configure(32'h00FF0000, 32'h0000FF00, 32'h000000FF, 24, 1'b1, 1);
    send(32'h00123456, "R5 swap24");
    chk("R5 red literal", 32'(out_red), 32'h56);
    configure(32'h0000F800, 32'h000007E0, 32'h0000001F, 16, 1'b1, 1);
    chk("R2 width_grn 565", 32'(width_grn), 32'd6);
    send(32'h0000ABCD, "R5 swap16");
    configure(32'hFF000000, 32'h00FF0000, 32'h000000FF, 32, 1'b1, 1);
    send(32'h11223344, "R5 swap32");
    chk("R5 blu literal", 32'(out_blu), 32'h11);
  endtask

  task automatic t_depth15();
    configure(32'h00007C00, 32'h000003E0, 32'h0000001F, 15, 1'b0, 1);
    send(32'h0000FFFF, "R6 d15 full");
    send(32'hFFFF8000, "R6 d15 unused bit");
    chk("R6 d15 red zero", 32'(out_red), 32'd0);
    configure(32'h00000006, 32'h00000000, 32'h00000001, 4, 1'b1, 1);
    send(32'h000000FF, "R6 d4");
  endtask

  task automatic t_odd_masks();
    configure(32'h0000000F, 32'h00000000, 32'h003FF000, 32, 1'b0, 1);
    chk("R4 shift_grn", 32'(shift_grn), 32'd0);
    chk("R4 width_grn", 32'(width_grn), 32'd0);
    chk("R1 shift_blu wide", 32'(shift_blu), 32'd12);
    chk("R2 width_blu wide", 32'(width_blu), 32'd10);
    chk("R8 tie rank_red", 32'(rank_red), 32'd0);
    chk("R8 tie rank_grn", 32'(rank_grn), 32'd1);
    chk("R8 tie rank_blu", 32'(rank_blu), 32'd2);
    send(32'hFFFFFFFF, "R4 zero mask");
    chk("R4 grn literal", 32'(out_grn), 32'd0);
    send(32'h00155A35, "R3 wide field");
    chk("R3 blu literal", 32'(out_blu), 32'h55);
  endtask

  task automatic t_scan_time();
    int cnt;
    configure(32'h00FF0000, 32'h0000FF00, 32'h000000FF, 24, 1'b0, 0);
    cnt = 0;
    while (!in_ready && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R9 scan cycles", 32'(cnt), 32'd32);
  endtask

  task automatic t_bad_depth();
    configure(32'h00000F00, 32'h000000F0, 32'h0000000F, 12, 1'b0, 0);
    repeat (40) @(negedge clk);
    chk("R7 depth 12 ready", 32'(in_ready), 32'd0);
    configure(32'h00000F00, 32'h000000F0, 32'h0000000F, 0, 1'b0, 0);
    repeat (40) @(negedge clk);
    chk("R7 depth 0 ready", 32'(in_ready), 32'd0);
    configure(32'h00000F00, 32'h000000F0, 32'h0000000F, 16, 1'b0, 1);
    chk("R7 depth 16 ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_backpressure();
    logic [31:0] wa, wb;
    configure(32'h00FF0000, 32'h0000FF00, 32'h000000FF, 24, 1'b0, 1);
    wa = prep(32'h00AABBCC);
    wb = prep(32'h00112233);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_pix = 32'h00AABBCC;
    @(posedge clk);
    @(negedge clk);
    in_pix = 32'h00112233;
    for (int k = 0; k < 3; k++) begin
      chk("R10 held valid", 32'(out_valid), 32'd1);
      chk("R10 no accept", 32'(in_ready), 32'd0);
      chk("R10 held red", 32'(out_red), 32'(field(wa, m_r)));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next valid", 32'(out_valid), 32'd1);
    chk("R10 next blu", 32'(out_blu), 32'(field(wb, m_b)));
    @(posedge clk);
    @(negedge clk);
    chk("R10 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rgb24();
    t_swap();
    t_depth15();
    t_odd_masks();
    t_scan_time();
    t_bad_depth();
    t_backpressure();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule